// File: doc/BRIEF.md
# Threshold Compare Monitor

This block observes the stream of conversion results that a converter writes into its result bank. A small number of independent monitor units, two by default, each watch a single chosen channel. Each unit compares every sample loaded for that channel against its own 12-bit threshold, using either an at-or-above test or a strictly-below test. It counts how many matching samples arrive in a row. A sticky flag is raised only once that run reaches the programmed match count plus one.

Samples and threshold are compared as unsigned numbers or as 12-bit two's complement numbers, chosen by a shared format input. Software clears a flag by writing 1 to it, which reaches the block as a one-cycle clear strobe. Each unit drives an interrupt request while its flag is set and its interrupt enable is on. Register decode, the converter and the channel sequencer are outside the block. The block receives one 32-bit configuration word per unit, a load strobe with channel and sample, and the clear strobes.

Top module: `thrmon_top`

## Requirements
- R1: After synchronous reset, every compare flag and every interrupt request is 0.
- R2: Each unit's 32-bit configuration word holds enable at bit 0, interrupt enable at bit 1, condition at bit 2, channel select at bits 5:3, match count at bits 11:8 and the threshold at bits 27:16; the other bits have no effect.
- R3: A load whose channel differs from a unit's channel select has no effect on that unit's run count or flag.
- R4: With condition 1, a sample on the selected channel matches when it is greater than or equal to the threshold.
- R5: With condition 0, a sample on the selected channel matches when it is strictly less than the threshold.
- R6: With format input 1, sample and threshold are ordered as 12-bit two's complement values; with 0 they are ordered as unsigned values.
- R7: The flag becomes 1 in the cycle after the load that brings the run of matching samples to match count plus one; the run count then restarts at zero.
- R8: A non-matching sample on the selected channel returns the run count to zero.
- R9: With enable at 0 no sample is compared and the run count is held at zero, so a later enable starts a fresh run.
- R10: The flag stays set until a clear strobe for that unit; a clear in the same cycle as a new set leaves the flag at 1.
- R11: A unit's interrupt request equals its flag ANDed with its interrupt enable.
- R12: Units share the load stream but keep separate counts, flags and configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_words | input | 32*NUM_UNITS | Per-unit configuration words, unit 0 in the low 32 bits |
| load_valid | input | 1 | A result is being loaded this cycle |
| load_chan | input | 3 | Channel index of the loaded result |
| load_sample | input | 12 | Loaded 12-bit result |
| fmt_signed | input | 1 | 1 = two's complement ordering, 0 = unsigned |
| flag_clr | input | NUM_UNITS | Write-1 clear strobe, one bit per unit |
| cmp_flag | output | NUM_UNITS | Sticky compare flags |
| cmp_irq | output | NUM_UNITS | Interrupt requests |

## Verification
The hardest states to reach from the ports are a set coinciding with a clear strobe, and a full run of sixteen consecutive matches at the largest match count. Random samples almost never hit the threshold on one channel sixteen times in a row. The bench therefore uses directed sequences for these cases, plus exact-threshold and sign-boundary samples. A seeded random phase then mixes channels, formats, sparse clears and configuration changes, with a bench model predicting every flag and interrupt.

// File: rtl/thrmon_pkg.sv
package thrmon_pkg;

    localparam int SAMPLE_W = 12;
    localparam int CHAN_W   = 3;
    localparam int MCNT_W   = 4;
    localparam int CFG_W    = 32;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CHAN_W-1:0]   chan_t;
    typedef logic [MCNT_W-1:0]   mcnt_t;

    typedef struct packed {
        logic [3:0]  rsv_hi;
        sample_t     thresh;
        logic [3:0]  rsv_mid;
        mcnt_t       mcount;
        logic [1:0]  rsv_lo;
        chan_t       chan;
        logic        ge_mode;
        logic        irq_en;
        logic        enable;
    } mon_cfg_t;

    // Map a sample to a key whose unsigned order equals the requested order.
    function automatic sample_t order_key(sample_t v, logic sgn);
        sample_t k;
        k = v;
        if (sgn) k[SAMPLE_W-1] = ~v[SAMPLE_W-1];
        return k;
    endfunction

    function automatic logic meets(sample_t s, sample_t t, logic sgn, logic ge);
        logic at_or_above;
        at_or_above = (order_key(s, sgn) >= order_key(t, sgn));
        return ge ? at_or_above : ~at_or_above;
    endfunction

endpackage

// File: rtl/thrmon_match.sv
module thrmon_match
    import thrmon_pkg::*;
(
    input  mon_cfg_t cfg,
    input  logic     load_valid,
    input  chan_t    load_chan,
    input  sample_t  load_sample,
    input  logic     fmt_signed,
    output logic     sel_hit,
    output logic     sel_miss
);
    logic sel_load;
    logic cond_ok;

    always_comb begin
        sel_load = load_valid && (load_chan == cfg.chan);
        cond_ok  = meets(load_sample, cfg.thresh, fmt_signed, cfg.ge_mode);
        sel_hit  = sel_load && cond_ok;
        sel_miss = sel_load && !cond_ok;
    end
endmodule

// File: rtl/thrmon_counter.sv
module thrmon_counter
    import thrmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  mcnt_t mcount,
    input  logic  sel_hit,
    input  logic  sel_miss,
    input  logic  clr,
    output logic  flag
);
    mcnt_t run_cnt;
    logic  run_done;

    always_comb begin
        run_done = enable && sel_hit && (run_cnt >= mcount);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else begin
            if (!enable)       run_cnt <= '0;
            else if (run_done) run_cnt <= '0;
            else if (sel_hit)  run_cnt <= run_cnt + 1'b1;
            else if (sel_miss) run_cnt <= '0;

            if (run_done)  flag <= 1'b1;
            else if (clr)  flag <= 1'b0;
        end
    end

    // R9: a disabled unit holds a zero count and never raises its flag
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (run_cnt == '0) && !$rose(flag));
    // R7: the count restarts whenever the flag rises
    a_r7_restart_on_set: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (run_cnt == '0));
    // R3: loads for other channels leave the count alone
    a_r3_other_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (enable && !sel_hit && !sel_miss) |=> $stable(run_cnt));
    // R8: a miss on the selected channel zeroes the count
    a_r8_miss_zeroes: assert property (@(posedge clk) disable iff (rst)
        (enable && sel_miss) |=> (run_cnt == '0));
    // R10: a clear without a new set drops the flag
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr && !sel_hit) |=> !flag);
    // R10: the flag only falls after a clear strobe
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/thrmon_unit.sv
module thrmon_unit
    import thrmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mon_cfg_t cfg,
    input  logic     load_valid,
    input  chan_t    load_chan,
    input  sample_t  load_sample,
    input  logic     fmt_signed,
    input  logic     clr,
    output logic     flag,
    output logic     irq
);
    logic sel_hit;
    logic sel_miss;

    thrmon_match u_match (
        .cfg         (cfg),
        .load_valid  (load_valid),
        .load_chan   (load_chan),
        .load_sample (load_sample),
        .fmt_signed  (fmt_signed),
        .sel_hit     (sel_hit),
        .sel_miss    (sel_miss)
    );

    thrmon_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg.enable),
        .mcount   (cfg.mcount),
        .sel_hit  (sel_hit),
        .sel_miss (sel_miss),
        .clr      (clr),
        .flag     (flag)
    );

    assign irq = flag & cfg.irq_en;
endmodule

// File: rtl/thrmon_top.sv
module thrmon_top
    import thrmon_pkg::*;
#(
    parameter int NUM_UNITS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_UNITS*CFG_W-1:0] cfg_words,
    input  logic                       load_valid,
    input  logic [CHAN_W-1:0]          load_chan,
    input  logic [SAMPLE_W-1:0]        load_sample,
    input  logic                       fmt_signed,
    input  logic [NUM_UNITS-1:0]       flag_clr,
    output logic [NUM_UNITS-1:0]       cmp_flag,
    output logic [NUM_UNITS-1:0]       cmp_irq
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        mon_cfg_t cfg_u;
        assign cfg_u = mon_cfg_t'(cfg_words[u*CFG_W +: CFG_W]);

        thrmon_unit u_unit (
            .clk         (clk),
            .rst         (rst),
            .cfg         (cfg_u),
            .load_valid  (load_valid),
            .load_chan   (load_chan),
            .load_sample (load_sample),
            .fmt_signed  (fmt_signed),
            .clr         (flag_clr[u]),
            .flag        (cmp_flag[u]),
            .irq         (cmp_irq[u])
        );

        // R11: no request without a raised flag
        a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
            cmp_irq[u] |-> cmp_flag[u]);
        // R1: outputs come out of reset cleared
        a_r1_reset_clear: assert property (@(posedge clk)
            rst |=> !cmp_flag[u] && !cmp_irq[u]);
    end
endmodule

// File: tb/thrmon_top_tb.sv
module thrmon_top_tb;
    localparam int NU = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   cfg_arr [NU];
    logic [NU*32-1:0] cfg_words;
    logic          load_valid;
    logic [2:0]    load_chan;
    logic [11:0]   load_sample;
    logic          fmt_signed;
    logic [NU-1:0] flag_clr;
    logic [NU-1:0] cmp_flag;
    logic [NU-1:0] cmp_irq;

    int n_checks = 0;
    int n_fails  = 0;
    int m_cnt  [NU];
    bit m_flag [NU];
    bit finished = 0;

    always #10 clk = ~clk;

    assign cfg_words = {cfg_arr[1], cfg_arr[0]};

    thrmon_top #(.NUM_UNITS(NU)) u_dut (
        .clk(clk), .rst(rst), .cfg_words(cfg_words),
        .load_valid(load_valid), .load_chan(load_chan),
        .load_sample(load_sample), .fmt_signed(fmt_signed),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    // R2 layout: en b0, ie b1, cond b2, chan b5:3, count b11:8, thresh b27:16
    function automatic logic [31:0] mk_cfg(bit en, bit ie, bit ge, int ch, int mc, int thr);
        logic [31:0] w;
        w = 32'h0;
        w[0] = en; w[1] = ie; w[2] = ge;
        w[5:3] = 3'(ch); w[11:8] = 4'(mc); w[27:16] = 12'(thr);
        return w;
    endfunction

    function automatic bit exp_match(logic [31:0] c, logic [11:0] s, bit f);
        int a, b;
        if (f) begin a = int'($signed(s)); b = int'($signed(c[27:16])); end
        else   begin a = int'(s);          b = int'(c[27:16]);          end
        return c[2] ? (a >= b) : (a < b);
    endfunction

    task automatic check(string tag, int u, bit act, bit exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s unit%0d %s actual=%0b expected=%0b", tag, u, what, act, exp);
        end
    endtask

    // Called just after a falling edge: drive, predict, then check at the next falling edge.
    task automatic step(string tag, bit lv, int ch, int smp, bit f, logic [NU-1:0] clr);
        load_valid = lv; load_chan = 3'(ch); load_sample = 12'(smp);
        fmt_signed = f; flag_clr = clr;
        for (int u = 0; u < NU; u++) begin
            bit set;
            set = 0;
            if (!cfg_arr[u][0]) m_cnt[u] = 0;
            else if (lv && cfg_arr[u][5:3] == 3'(ch)) begin
                if (exp_match(cfg_arr[u], 12'(smp), f)) begin
                    m_cnt[u]++;
                    if (m_cnt[u] >= int'(cfg_arr[u][11:8]) + 1) begin
                        set = 1; m_cnt[u] = 0;
                    end
                end else m_cnt[u] = 0;
            end
            if (set) m_flag[u] = 1;
            else if (clr[u]) m_flag[u] = 0;
        end
        @(negedge clk);
        for (int u = 0; u < NU; u++) begin
            check(tag, u, cmp_flag[u], m_flag[u], "flag");
            check("R11", u, cmp_irq[u], m_flag[u] & cfg_arr[u][1], "irq");
        end
    endtask

    task automatic clear_all();
        step("R10", 0, 0, 0, 0, '1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED));
        rst = 1; load_valid = 0; load_chan = 0; load_sample = 0;
        fmt_signed = 0; flag_clr = 0;
        cfg_arr[0] = 32'h0; cfg_arr[1] = 32'h0;
        for (int u = 0; u < NU; u++) begin m_cnt[u] = 0; m_flag[u] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        for (int u = 0; u < NU; u++) begin
            check("R1", u, cmp_flag[u], 0, "flag after reset");
            check("R1", u, cmp_irq[u], 0, "irq after reset");
        end

        // R4, R3, R7: ge mode, channel 2, count 2 -> third match sets
        cfg_arr[0] = mk_cfg(1, 1, 1, 2, 2, 'h100) | 32'hF000_F0C0; // R2: spare bits set
        step("R4", 1, 2, 'h100, 0, 0);
        step("R4", 1, 2, 'h200, 0, 0);
        step("R3", 1, 5, 'h300, 0, 0);
        step("R3", 1, 3, 'h000, 0, 0);
        step("R7", 1, 2, 'h150, 0, 0);
        check("R7", 0, cmp_flag[0], 1, "flag after third match");
        step("R10", 1, 2, 'h050, 0, 0);
        check("R10", 0, cmp_flag[0], 1, "flag sticky");
        clear_all();
        check("R10", 0, cmp_flag[0], 0, "flag cleared");

        // R8: a miss breaks the run
        step("R8", 1, 2, 'h100, 0, 0);
        step("R8", 1, 2, 'h101, 0, 0);
        step("R8", 1, 2, 'h0FF, 0, 0);
        step("R8", 1, 2, 'h100, 0, 0);
        step("R8", 1, 2, 'h100, 0, 0);
        check("R8", 0, cmp_flag[0], 0, "no flag after broken run");
        // R10: set wins over simultaneous clear
        step("R10", 1, 2, 'hFFF, 0, 2'b01);
        check("R10", 0, cmp_flag[0], 1, "set beats clear");
        clear_all();

        // R5: lt mode, single match
        cfg_arr[0] = mk_cfg(1, 1, 0, 4, 0, 'h100);
        step("R5", 1, 4, 'h100, 0, 0);
        check("R5", 0, cmp_flag[0], 0, "equal is not below");
        step("R5", 1, 4, 'h0FF, 0, 0);
        check("R5", 0, cmp_flag[0], 1, "below threshold");
        clear_all();

        // R6: signed vs unsigned ordering on unit 1
        cfg_arr[0] = 32'h0;
        cfg_arr[1] = mk_cfg(1, 1, 1, 1, 0, 'h000);
        step("R6", 1, 1, 'h800, 1, 0);
        check("R6", 1, cmp_flag[1], 0, "-2048 below 0 signed");
        step("R6", 1, 1, 'h7FF, 1, 0);
        check("R6", 1, cmp_flag[1], 1, "2047 at or above 0 signed");
        clear_all();
        cfg_arr[1] = mk_cfg(1, 1, 1, 1, 0, 'hFFF);
        step("R6", 1, 1, 'h000, 1, 0);
        check("R6", 1, cmp_flag[1], 1, "0 above -1 signed");
        clear_all();
        step("R6", 1, 1, 'h000, 0, 0);
        check("R6", 1, cmp_flag[1], 0, "0 below 4095 unsigned");

        // R9: disabled unit ignores matches and restarts when enabled
        cfg_arr[1] = mk_cfg(0, 1, 1, 1, 1, 'h000);
        step("R9", 1, 1, 'h010, 0, 0);
        step("R9", 1, 1, 'h010, 0, 0);
        check("R9", 1, cmp_flag[1], 0, "disabled");
        cfg_arr[1] = mk_cfg(1, 1, 1, 1, 1, 'h000);
        step("R9", 1, 1, 'h010, 0, 0);
        check("R9", 1, cmp_flag[1], 0, "fresh run after enable");
        step("R9", 1, 1, 'h010, 0, 0);
        check("R9", 1, cmp_flag[1], 1, "second match after enable");
        clear_all();

        // R12: both units on one channel, opposite conditions
        cfg_arr[0] = mk_cfg(1, 1, 1, 6, 0, 'h400);
        cfg_arr[1] = mk_cfg(1, 0, 0, 6, 1, 'h400);
        step("R12", 1, 6, 'h100, 0, 0);
        step("R12", 1, 6, 'h100, 0, 0);
        check("R12", 1, cmp_flag[1], 1, "below unit");
        check("R12", 0, cmp_flag[0], 0, "above unit");
        check("R11", 1, cmp_irq[1], 0, "irq masked");
        step("R12", 1, 6, 'h500, 0, 2'b10);
        check("R12", 0, cmp_flag[0], 1, "above unit set");
        check("R12", 1, cmp_flag[1], 0, "below unit cleared");
        clear_all();

        // R7: largest match count needs sixteen matches
        cfg_arr[0] = mk_cfg(1, 1, 1, 7, 15, 'h000);
        cfg_arr[1] = 32'h0;
        for (int i = 0; i < 15; i++) step("R7", 1, 7, i, 0, 0);
        check("R7", 0, cmp_flag[0], 0, "fifteen matches");
        step("R7", 1, 7, 'h123, 0, 0);
        check("R7", 0, cmp_flag[0], 1, "sixteenth match");
        clear_all();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 150 == 0) begin
                for (int u = 0; u < NU; u++)
                    cfg_arr[u] = mk_cfg(($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                                        $urandom % 4, $urandom % 4, $urandom % 4096);
            end
            step("R7", ($urandom % 4) != 0, $urandom % 4, $urandom % 4096, $urandom % 2,
                 (($urandom % 10) == 0) ? 2'($urandom % 4) : 2'b00);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule